// File: doc/BRIEF.md
# Hot-plug detect interrupt unit

This block watches the raw hot-plug-detect line of a display transmitter and turns it into a clean connection level. It also turns the line into interrupt events. The raw line is first brought into the clock domain by a multi-flop synchronizer. A programmable glitch filter then acts on it, controlled by two settings. A prescaler sets how often the line is sampled. A stable-sample count sets how many consecutive differing samples are needed before the filtered level follows the line.

Each change of the filtered level raises a sticky event. A connect (rising) change and a disconnect (falling) change have separate event bits. A level interrupt from a neighbouring controller core is merged into the same status word. Software clears any status bit by writing a one to it in a dedicated clear register. An active-high enable mask selects which status bits drive the single registered interrupt output. All registers sit behind a plain register port that has a write strobe and a combinational read.

Register map (offsets on `reg_addr`):

| Offset | Access | Content |
|--------|--------|---------|
| 0 | read | bit 0: filtered connection level (1 = connected) |
| 1 | read | status: bit 0 core, bit 1 connect event, bit 2 disconnect event |
| 2 | write | clear: each 1 clears that status bit; reads as 0 |
| 3 | read/write | enable mask, bits 2:0, same bit layout as the status word |
| 4 | read/write | filter setup: bits 15:12 prescale, bits 7:0 stable-sample count |

Top module: `hpd_irq_unit`

## Requirements
- R1: After reset, the level register (offset 0) and the status register (offset 1) read 0. The mask register (offset 3) reads 0 and `irq_out` is 0. The filter setup register (offset 4) reads 0xA0A0, which is prescale 0xA in bits 15:12 and count 0xA0 in bits 7:0.
- R2: With prescale P, the count field C (bits 7:0 of offset 4) sets the stable-sample count. The filtered level changes only after C consecutive samples that differ from it. A C of 0 acts as 1. With P = 0 and C = 4, a 3-cycle high glitch on `hpd_raw` leaves the level and the status at 0.
- R3: The prescale field P (bits 15:12 of offset 4) makes the filter take one sample every P+1 clocks. With P = 3 and C = 4, a 12-cycle pulse is ignored. A 30-cycle pulse is accepted.
- R4: A change of the filtered level from 0 to 1 sets status bit 1.
- R5: A change of the filtered level from 1 to 0 sets status bit 2.
- R6: While `core_irq` is high, status bit 0 is set each cycle. The bit stays set after `core_irq` falls, until it is cleared.
- R7: Status bits are sticky. Writing offset 2 clears exactly the bits written as 1. Bits written as 0 are unchanged. Offset 2 reads as 0.
- R8: When an event sets a status bit in the same cycle as a clear of that bit, the bit stays set.
- R9: `irq_out` is registered. It is 1 exactly when some status bit is set whose mask bit (offset 3, active-high) is also 1.
- R10: Bit 0 of offset 0 reads 1 while the filtered level is connected and 0 while it is disconnected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| hpd_raw | input | 1 | asynchronous hot-plug-detect line |
| core_irq | input | 1 | level interrupt from the neighbouring core |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | 3 | register offset |
| reg_wdata | input | 16 | register write data |
| reg_rdata | output | 16 | register read data (combinational) |
| irq_out | output | 1 | combined interrupt |

## Verification
The filter is tried with pulses just short of the stable-sample count and well beyond it, first with no prescale and then with a prescale. These patterns separate a correct count from an off-by-one, and show whether the prescaler is applied. A connect and then a disconnect show that the two event bits are kept apart. Clear writes with zero bits, with a single bit, and during an active core interrupt separate sticky behaviour from lost events. Masking each source alone separates per-bit enables from a global OR.

// File: rtl/hpd_irq_pkg.sv
package hpd_irq_pkg;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 3;
    localparam int NSRC    = 3;
    localparam int PRE_W   = 4;
    localparam int THR_W   = 8;
    localparam int PRE_LSB = 12;

    localparam int SRC_CORE = 0;
    localparam int SRC_RISE = 1;
    localparam int SRC_FALL = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_LEVEL = 3'd0,
        RA_STAT  = 3'd1,
        RA_CLR   = 3'd2,
        RA_MASK  = 3'd3,
        RA_FILT  = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [THR_W-1:0] thr;
    } filt_cfg_t;

    function automatic logic [DATA_W-1:0] cfg_to_word(filt_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[PRE_LSB +: PRE_W] = c.pre;
        w[THR_W-1:0]        = c.thr;
        return w;
    endfunction

    function automatic filt_cfg_t word_to_cfg(logic [DATA_W-1:0] w);
        filt_cfg_t c;
        c.pre = w[PRE_LSB +: PRE_W];
        c.thr = w[THR_W-1:0];
        return c;
    endfunction
endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/hpd_glitch_filter.sv
module hpd_glitch_filter
    import hpd_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      din,
    input  filt_cfg_t cfg,
    output logic      level,
    output logic      rise_ev,
    output logic      fall_ev
);
    logic [PRE_W-1:0] pcnt;
    logic [THR_W-1:0] scnt;
    logic [THR_W-1:0] last;
    logic             tick;

    assign tick = (pcnt >= cfg.pre);
    assign last = (cfg.thr == '0) ? '0 : cfg.thr - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt    <= '0;
            scnt    <= '0;
            level   <= 1'b0;
            rise_ev <= 1'b0;
            fall_ev <= 1'b0;
        end else begin
            rise_ev <= 1'b0;
            fall_ev <= 1'b0;
            pcnt    <= tick ? '0 : pcnt + 1'b1;
            if (din == level) begin
                scnt <= '0;
            end else if (tick) begin
                if (scnt >= last) begin
                    level   <= din;
                    scnt    <= '0;
                    rise_ev <= din;
                    fall_ev <= ~din;
                end else begin
                    scnt <= scnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hpd_irq_regs.sv
module hpd_irq_regs
    import hpd_irq_pkg::*;
#(
    parameter logic [PRE_W-1:0] RST_PRE = 4'hA,
    parameter logic [THR_W-1:0] RST_THR = 8'hA0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              level,
    input  logic              rise_ev,
    input  logic              fall_ev,
    input  logic              core_irq,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NSRC-1:0]   stat,
    output logic [NSRC-1:0]   msk,
    output filt_cfg_t         cfg,
    output logic              irq
);
    logic [NSRC-1:0] set_v;
    logic [NSRC-1:0] clr_v;

    always_comb begin
        set_v           = '0;
        set_v[SRC_CORE] = core_irq;
        set_v[SRC_RISE] = rise_ev;
        set_v[SRC_FALL] = fall_ev;
        clr_v = (reg_wr && reg_addr == RA_CLR) ? reg_wdata[NSRC-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat    <= '0;
            msk     <= '0;
            cfg.pre <= RST_PRE;
            cfg.thr <= RST_THR;
            irq     <= 1'b0;
        end else begin
            stat <= (stat & ~clr_v) | set_v;
            irq  <= |(stat & msk);
            if (reg_wr && reg_addr == RA_MASK) msk <= reg_wdata[NSRC-1:0];
            if (reg_wr && reg_addr == RA_FILT) cfg <= word_to_cfg(reg_wdata);
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_LEVEL: reg_rdata[0]        = level;
            RA_STAT:  reg_rdata[NSRC-1:0] = stat;
            RA_MASK:  reg_rdata[NSRC-1:0] = msk;
            RA_FILT:  reg_rdata           = cfg_to_word(cfg);
            default:  reg_rdata           = '0;
        endcase
    end
endmodule

// File: rtl/hpd_irq_unit.sv
module hpd_irq_unit
    import hpd_irq_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter logic [PRE_W-1:0] RST_PRE     = 4'hA,
    parameter logic [THR_W-1:0] RST_THR     = 8'hA0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hpd_raw,
    input  logic              core_irq,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_out
);
    logic            sync_lvl;
    logic            filt_lvl;
    logic            rise_ev;
    logic            fall_ev;
    logic [NSRC-1:0] stat;
    logic [NSRC-1:0] msk;
    filt_cfg_t       cfg;

    hpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (hpd_raw),
        .dout(sync_lvl)
    );

    hpd_glitch_filter u_filt (
        .clk    (clk),
        .rst    (rst),
        .din    (sync_lvl),
        .cfg    (cfg),
        .level  (filt_lvl),
        .rise_ev(rise_ev),
        .fall_ev(fall_ev)
    );

    hpd_irq_regs #(.RST_PRE(RST_PRE), .RST_THR(RST_THR)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .level    (filt_lvl),
        .rise_ev  (rise_ev),
        .fall_ev  (fall_ev),
        .core_irq (core_irq),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .stat     (stat),
        .msk      (msk),
        .cfg      (cfg),
        .irq      (irq_out)
    );
endmodule

// File: rtl/hpd_irq_chk.sv
module hpd_irq_chk
    import hpd_irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sync_lvl,
    input logic              filt_lvl,
    input logic [NSRC-1:0]   stat,
    input logic [NSRC-1:0]   msk,
    input logic              irq_out,
    input logic              core_irq,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata
);
    logic clr1;
    assign clr1 = reg_wr && (reg_addr == RA_CLR) && reg_wdata[SRC_RISE];

    a_r2_hold_when_equal: assert property (@(posedge clk) disable iff (rst)
        (sync_lvl == filt_lvl) |=> $stable(filt_lvl));

    a_r4_rise_event: assert property (@(posedge clk) disable iff (rst)
        $rose(filt_lvl) |=> stat[SRC_RISE]);

    a_r5_fall_event: assert property (@(posedge clk) disable iff (rst)
        $fell(filt_lvl) |=> stat[SRC_FALL]);

    a_r6_core_sets: assert property (@(posedge clk) disable iff (rst)
        core_irq |=> stat[SRC_CORE]);

    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (stat[SRC_RISE] && !clr1) |=> stat[SRC_RISE]);

    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (msk == '0) |=> !irq_out);
endmodule

bind hpd_irq_unit hpd_irq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .sync_lvl (sync_lvl),
    .filt_lvl (filt_lvl),
    .stat     (stat),
    .msk      (msk),
    .irq_out  (irq_out),
    .core_irq (core_irq),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata)
);

// File: tb/hpd_irq_unit_tb.sv
module hpd_irq_unit_tb;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hpd_raw = 1'b0;
    logic        core_irq = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        irq_out;

    int total = 0;
    int bad = 0;
    logic [15:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    hpd_irq_unit u_dut (
        .clk(clk), .rst(rst), .hpd_raw(hpd_raw), .core_irq(core_irq),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 16'd0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse_hpd(input logic val, input int n);
        @(negedge clk);
        hpd_raw = val;
        cycles(n);
        hpd_raw = ~val;
    endtask

    task automatic t_reset;
        rd(3'd0, rv); check("R1 level", rv, 16'h0);
        check("R10 level disconnected", rv, 16'h0);
        rd(3'd1, rv); check("R1 status", rv, 16'h0);
        rd(3'd3, rv); check("R1 mask", rv, 16'h0);
        rd(3'd4, rv); check("R1 filter setup", rv, 16'hA0A0);
        check("R1 irq", {15'd0, irq_out}, 16'h0);
    endtask

    task automatic t_glitch;
        wr(3'd4, 16'h0004);
        cycles(4);
        pulse_hpd(1'b1, 3);
        cycles(15);
        rd(3'd0, rv); check("R2 short glitch level", rv, 16'h0);
        rd(3'd1, rv); check("R2 short glitch status", rv, 16'h0);
    endtask

    task automatic t_connect;
        @(negedge clk); hpd_raw = 1'b1;
        cycles(15);
        rd(3'd0, rv); check("R10 level connected", rv, 16'h1);
        rd(3'd1, rv); check("R4 rise bit", rv, 16'h2);
        check("R9 masked off", {15'd0, irq_out}, 16'h0);
        wr(3'd3, 16'h0002);
        cycles(3);
        check("R9 enabled rise", {15'd0, irq_out}, 16'h1);
        wr(3'd2, 16'h0000);
        rd(3'd1, rv); check("R7 zero write keeps", rv, 16'h2);
        rd(3'd2, rv); check("R7 clear reads zero", rv, 16'h0);
        wr(3'd2, 16'h0002);
        rd(3'd1, rv); check("R7 clear bit1", rv, 16'h0);
        cycles(3);
        check("R9 irq drops", {15'd0, irq_out}, 16'h0);
    endtask

    task automatic t_disconnect;
        @(negedge clk); hpd_raw = 1'b0;
        cycles(15);
        rd(3'd0, rv); check("R10 level back to 0", rv, 16'h0);
        rd(3'd1, rv); check("R5 fall bit only", rv, 16'h4);
        cycles(2);
        check("R9 other bit masked", {15'd0, irq_out}, 16'h0);
        wr(3'd2, 16'h0004);
        rd(3'd1, rv); check("R7 clear bit2", rv, 16'h0);
    endtask

    task automatic t_core;
        wr(3'd3, 16'h0001);
        @(negedge clk); core_irq = 1'b1;
        cycles(2);
        core_irq = 1'b0;
        cycles(3);
        rd(3'd1, rv); check("R6 core sticky", rv, 16'h1);
        check("R9 core enabled", {15'd0, irq_out}, 16'h1);
        @(negedge clk); core_irq = 1'b1;
        wr(3'd2, 16'h0001);
        rd(3'd1, rv); check("R8 event beats clear", rv, 16'h1);
        core_irq = 1'b0;
        wr(3'd2, 16'h0001);
        rd(3'd1, rv); check("R6 core cleared", rv, 16'h0);
        wr(3'd3, 16'h0000);
    endtask

    task automatic t_prescale;
        wr(3'd4, 16'h3004);
        rd(3'd4, rv); check("R3 setup readback", rv, 16'h3004);
        cycles(4);
        pulse_hpd(1'b1, 12);
        cycles(30);
        rd(3'd0, rv); check("R3 short pulse ignored", rv, 16'h0);
        pulse_hpd(1'b1, 30);
        cycles(2);
        rd(3'd0, rv); check("R3 long pulse accepted", rv, 16'h1);
        cycles(40);
        rd(3'd1, rv); check("R3 both events", rv, 16'h6);
    endtask

    initial begin
        cycles(3);
        rst = 1'b0;
        cycles(2);
        t_reset();
        t_glitch();
        t_connect();
        t_disconnect();
        t_core();
        t_prescale();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule